// File: doc/BRIEF.md
# Nested zero-overhead loop controller

This block runs hardware loops for a single-issue instruction fetch path. It holds three loop controllers. Each one has a first-instruction address, a last-instruction address, a live iteration count, a reload count and an enable bit. In every cycle that fetch advances, the block compares the fetch address with the last-instruction address of every enabled controller. When a controller decides to loop back, the block asserts a redirect in the same cycle, so the taken branch costs no extra instruction slot.

Nesting works through the reload count. When an inner loop runs out, its live count returns to the reload value. This leaves it ready for the next pass of the enclosing loop. Several controllers may share one last-instruction address. In that case the lowest-numbered one counts as innermost and is evaluated first.

Every loop register can be read and written through a register-file style port. Because the datapath can write a computed value into a count register, a run-time result decides whether the next back-branch is taken. A controller set up with a far-away first-instruction address also gives a branch to a patch location that costs no cycles.

Top module: `hwl_unit`

## Requirements
- R1: After reset, every loop register reads 0, every controller is disabled, and no redirect is raised.
- R2: Register index = slot*8 + field, with field 0 = first-instruction address, 1 = last-instruction address, 2 = live count (low 16 bits), 3 = reload count (low 16 bits), 4 = control (bit 0 = enable). A write lands at the clock edge and reads back from the next cycle. Reads are combinational and zero-extend the narrower fields.
- R3: When fetch is valid, the controller is enabled, the fetch address equals its last-instruction address and its live count is nonzero, then redirect is high in that cycle with the target equal to its first-instruction address, and the live count drops by one at the clock edge.
- R4: When the same match meets a live count of zero, no branch is taken for that controller, and its live count is loaded from its reload count at the clock edge.
- R5: A disabled controller, or any controller in a cycle without valid fetch, neither redirects nor changes its count.
- R6: Matching controllers are evaluated from slot 0 upward. The first one with a nonzero count takes the branch. Every lower-numbered matching controller reloads. Every higher-numbered one is left untouched.
- R7: A register write in the same cycle as a loop decrement or reload wins for the register it names. Loop evaluation in that cycle uses the values from before the write.
- R8: loop_hit is one-hot or zero and marks the controller taking the branch. redirect is high exactly when loop_hit is nonzero.
- R9: A write to an index with slot 3 or field 5 to 7 changes nothing, and a read from such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch advances this cycle |
| fetch_pc | input | 32 | Address being fetched |
| redirect | output | 1 | Replace the sequential next address with redirect_target |
| redirect_target | output | 32 | First-instruction address of the looping controller |
| loop_hit | output | 3 | One bit per controller, set for the controller taking the branch |
| rf_we | input | 1 | Loop register write strobe |
| rf_waddr | input | 5 | Loop register write index (slot*8 + field) |
| rf_wdata | input | 32 | Loop register write data |
| rf_raddr | input | 5 | Loop register read index |
| rf_rdata | output | 32 | Loop register read data |

## Verification
A loop back-branch or a fall-through reload can land in the same cycle as a datapath write to the count register it touches. That is the collision that matters here. The bench forces it in a directed case, where the live count is written in the very cycle the fetch address reaches the last-instruction address. It also forces it continually in the random phase, where writes hit a small index space while the fetch address wanders over a small address window. The reference model judges each such cycle: the branch decision comes from the old count, and the written value is the one that survives to the next cycle.

// File: rtl/hwl_pkg.sv
package hwl_pkg;

  localparam int FIELD_W = 3;

  typedef enum logic [FIELD_W-1:0] {
    FLD_START = 3'd0,
    FLD_END   = 3'd1,
    FLD_COUNT = 3'd2,
    FLD_INIT  = 3'd3,
    FLD_CTRL  = 3'd4
  } hwl_field_e;

  function automatic logic field_is_mapped(input logic [FIELD_W-1:0] f);
    return f <= FLD_CTRL;
  endfunction

endpackage

// File: rtl/hwl_slot.sv
module hwl_slot
  import hwl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_field,
  input  logic [ADDR_W-1:0]  wr_data,
  input  logic               loop_dec,
  input  logic               loop_reload,
  output logic [ADDR_W-1:0]  start_q,
  output logic [ADDR_W-1:0]  end_q,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [CNT_W-1:0]   init_q,
  output logic               en_q
);

  logic              start_ld, end_ld, cnt_ld, init_ld, en_ld;
  logic              wr_cnt;
  logic [CNT_W-1:0]  cnt_nxt;

  // next-state: datapath write has priority over loop bookkeeping
  always_comb begin
    start_ld = wr_en && (wr_field == FLD_START);
    end_ld   = wr_en && (wr_field == FLD_END);
    init_ld  = wr_en && (wr_field == FLD_INIT);
    en_ld    = wr_en && (wr_field == FLD_CTRL);
    wr_cnt   = wr_en && (wr_field == FLD_COUNT);
    cnt_ld   = wr_cnt || loop_dec || loop_reload;
    if (wr_cnt) begin
      cnt_nxt = wr_data[CNT_W-1:0];
    end else if (loop_dec) begin
      cnt_nxt = cnt_q - 1'b1;
    end else begin
      cnt_nxt = init_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
      init_q  <= '0;
      en_q    <= 1'b0;
    end else begin
      if (start_ld) start_q <= wr_data;
      if (end_ld)   end_q   <= wr_data;
      if (cnt_ld)   cnt_q   <= cnt_nxt;
      if (init_ld)  init_q  <= wr_data[CNT_W-1:0];
      if (en_ld)    en_q    <= wr_data[0];
    end
  end

endmodule

// File: rtl/hwl_arb.sv
module hwl_arb #(
  parameter int NUM_LOOPS = 3,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16
) (
  input  logic                                fetch_valid,
  input  logic [ADDR_W-1:0]                   fetch_pc,
  input  logic [NUM_LOOPS-1:0]                en_q,
  input  logic [NUM_LOOPS-1:0][ADDR_W-1:0]    start_q,
  input  logic [NUM_LOOPS-1:0][ADDR_W-1:0]    end_q,
  input  logic [NUM_LOOPS-1:0][CNT_W-1:0]     cnt_q,
  output logic [NUM_LOOPS-1:0]                loop_dec,
  output logic [NUM_LOOPS-1:0]                loop_reload,
  output logic [ADDR_W-1:0]                   target
);

  logic [NUM_LOOPS-1:0] match;
  logic                 blocked;

  // innermost (lowest slot) first; a taken branch shields outer slots
  always_comb begin
    blocked     = 1'b0;
    loop_dec    = '0;
    loop_reload = '0;
    target      = '0;
    for (int i = 0; i < NUM_LOOPS; i++) begin
      match[i] = fetch_valid && en_q[i] && (end_q[i] == fetch_pc);
      if (match[i] && !blocked) begin
        if (cnt_q[i] != '0) begin
          loop_dec[i] = 1'b1;
          target      = start_q[i];
          blocked     = 1'b1;
        end else begin
          loop_reload[i] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hwl_rdmux.sv
module hwl_rdmux
  import hwl_pkg::*;
#(
  parameter int NUM_LOOPS = 3,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int IDX_W     = 2
) (
  input  logic [IDX_W+FIELD_W-1:0]            raddr,
  input  logic [NUM_LOOPS-1:0]                en_q,
  input  logic [NUM_LOOPS-1:0][ADDR_W-1:0]    start_q,
  input  logic [NUM_LOOPS-1:0][ADDR_W-1:0]    end_q,
  input  logic [NUM_LOOPS-1:0][CNT_W-1:0]     cnt_q,
  input  logic [NUM_LOOPS-1:0][CNT_W-1:0]     init_q,
  output logic [ADDR_W-1:0]                   rdata
);

  localparam int PAD_W = ADDR_W - CNT_W;

  logic [IDX_W-1:0]   rslot;
  logic [FIELD_W-1:0] rfield;

  always_comb begin
    rslot  = raddr[IDX_W+FIELD_W-1:FIELD_W];
    rfield = raddr[FIELD_W-1:0];
    rdata  = '0;
    for (int i = 0; i < NUM_LOOPS; i++) begin
      if (rslot == IDX_W'(i)) begin
        case (rfield)
          FLD_START: rdata = start_q[i];
          FLD_END:   rdata = end_q[i];
          FLD_COUNT: rdata = {{PAD_W{1'b0}}, cnt_q[i]};
          FLD_INIT:  rdata = {{PAD_W{1'b0}}, init_q[i]};
          FLD_CTRL:  rdata = {{(ADDR_W-1){1'b0}}, en_q[i]};
          default:   rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/hwl_unit.sv
module hwl_unit
  import hwl_pkg::*;
#(
  parameter int  NUM_LOOPS = 3,
  parameter int  ADDR_W    = 32,
  parameter int  CNT_W     = 16,
  localparam int IDX_W     = (NUM_LOOPS > 1) ? $clog2(NUM_LOOPS) : 1,
  localparam int RA_W      = IDX_W + FIELD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_valid,
  input  logic [ADDR_W-1:0]    fetch_pc,
  output logic                 redirect,
  output logic [ADDR_W-1:0]    redirect_target,
  output logic [NUM_LOOPS-1:0] loop_hit,
  input  logic                 rf_we,
  input  logic [RA_W-1:0]      rf_waddr,
  input  logic [ADDR_W-1:0]    rf_wdata,
  input  logic [RA_W-1:0]      rf_raddr,
  output logic [ADDR_W-1:0]    rf_rdata
);

  logic [NUM_LOOPS-1:0]             en_q;
  logic [NUM_LOOPS-1:0][ADDR_W-1:0] start_q;
  logic [NUM_LOOPS-1:0][ADDR_W-1:0] end_q;
  logic [NUM_LOOPS-1:0][CNT_W-1:0]  cnt_q;
  logic [NUM_LOOPS-1:0][CNT_W-1:0]  init_q;
  logic [NUM_LOOPS-1:0]             loop_dec;
  logic [NUM_LOOPS-1:0]             loop_reload;
  logic [NUM_LOOPS-1:0]             slot_we;

  logic [IDX_W-1:0]   wr_slot;
  logic [FIELD_W-1:0] wr_field;

  always_comb begin
    wr_slot  = rf_waddr[RA_W-1:FIELD_W];
    wr_field = rf_waddr[FIELD_W-1:0];
    for (int i = 0; i < NUM_LOOPS; i++) begin
      slot_we[i] = rf_we && (wr_slot == IDX_W'(i)) && field_is_mapped(wr_field);
    end
  end

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_slot
    hwl_slot #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
    ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (slot_we[g]),
      .wr_field    (wr_field),
      .wr_data     (rf_wdata),
      .loop_dec    (loop_dec[g]),
      .loop_reload (loop_reload[g]),
      .start_q     (start_q[g]),
      .end_q       (end_q[g]),
      .cnt_q       (cnt_q[g]),
      .init_q      (init_q[g]),
      .en_q        (en_q[g])
    );
  end

  hwl_arb #(
    .NUM_LOOPS (NUM_LOOPS),
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W)
  ) u_arb (
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .en_q        (en_q),
    .start_q     (start_q),
    .end_q       (end_q),
    .cnt_q       (cnt_q),
    .loop_dec    (loop_dec),
    .loop_reload (loop_reload),
    .target      (redirect_target)
  );

  hwl_rdmux #(
    .NUM_LOOPS (NUM_LOOPS),
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .IDX_W     (IDX_W)
  ) u_rdmux (
    .raddr   (rf_raddr),
    .en_q    (en_q),
    .start_q (start_q),
    .end_q   (end_q),
    .cnt_q   (cnt_q),
    .init_q  (init_q),
    .rdata   (rf_rdata)
  );

  assign loop_hit = loop_dec;
  assign redirect = |loop_dec;

endmodule

// File: rtl/hwl_unit_chk.sv
module hwl_unit_chk
  import hwl_pkg::*;
#(
  parameter int NUM_LOOPS = 3,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int RA_W      = 5
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             fetch_valid,
  input logic                             redirect,
  input logic [ADDR_W-1:0]                redirect_target,
  input logic [NUM_LOOPS-1:0]             loop_hit,
  input logic                             rf_we,
  input logic [RA_W-1:0]                  rf_waddr,
  input logic [CNT_W-1:0]                 rf_wdata_lo,
  input logic [NUM_LOOPS-1:0]             en_q,
  input logic [NUM_LOOPS-1:0][ADDR_W-1:0] start_q,
  input logic [NUM_LOOPS-1:0][CNT_W-1:0]  cnt_q
);

  // R8: at most one controller takes the branch
  a_r8_hit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(loop_hit));

  // R5: no fetch, no redirect
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> !redirect);

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_chk
    localparam logic [RA_W-1:0] CNT_IDX = RA_W'(g * 8 + int'(FLD_COUNT));

    // R3: branch goes to this controller's first-instruction address
    a_r3_target: assert property (@(posedge clk) disable iff (!rst_n)
      loop_hit[g] |-> (redirect_target == start_q[g]));

    // R3: taken branch decrements the live count
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_hit[g] && !(rf_we && rf_waddr == CNT_IDX))
      |=> (cnt_q[g] == CNT_W'($past(cnt_q[g]) - 1'b1)));

    // R4: an expired count never branches
    a_r4_zero_falls: assert property (@(posedge clk) disable iff (!rst_n)
      loop_hit[g] |-> (cnt_q[g] != '0));

    // R5: disabled controller never branches
    a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[g] |-> !loop_hit[g]);

    // R7: datapath write to the count wins over loop bookkeeping
    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && rf_waddr == CNT_IDX) |=> (cnt_q[g] == $past(rf_wdata_lo)));
  end

endmodule

bind hwl_unit hwl_unit_chk #(
  .NUM_LOOPS (NUM_LOOPS),
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W),
  .RA_W      (RA_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .fetch_valid     (fetch_valid),
  .redirect        (redirect),
  .redirect_target (redirect_target),
  .loop_hit        (loop_hit),
  .rf_we           (rf_we),
  .rf_waddr        (rf_waddr),
  .rf_wdata_lo     (rf_wdata[CNT_W-1:0]),
  .en_q            (en_q),
  .start_q         (start_q),
  .cnt_q           (cnt_q)
);

// File: tb/hwl_unit_bench.sv
module hwl_unit_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        redirect;
  logic [31:0] redirect_target;
  logic [2:0]  loop_hit;
  logic        rf_we = 1'b0;
  logic [4:0]  rf_waddr = '0;
  logic [31:0] rf_wdata = '0;
  logic [4:0]  rf_raddr = '0;
  logic [31:0] rf_rdata;

  int nchk = 0;
  int nfail = 0;

  // reference state
  logic [31:0] m_start [3];
  logic [31:0] m_end   [3];
  logic [15:0] m_cnt   [3];
  logic [15:0] m_init  [3];
  logic        m_en    [3];

  logic        e_red;
  logic [31:0] e_tgt;
  int          n_taken;
  int          n_fall;

  always #(CLK_P/2) clk = ~clk;

  hwl_unit u_hwl_unit (
    .clk (clk), .rst_n (rst_n), .fetch_valid (fetch_valid), .fetch_pc (fetch_pc),
    .redirect (redirect), .redirect_target (redirect_target), .loop_hit (loop_hit),
    .rf_we (rf_we), .rf_waddr (rf_waddr), .rf_wdata (rf_wdata),
    .rf_raddr (rf_raddr), .rf_rdata (rf_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void m_reset();
    for (int i = 0; i < 3; i++) begin
      m_start[i] = '0; m_end[i] = '0; m_cnt[i] = '0; m_init[i] = '0; m_en[i] = 1'b0;
    end
  endfunction

  // R6 ordering: lowest slot first, taken branch stops the scan
  function automatic void m_eval(input logic v, input logic [31:0] pc,
                                 output int hit, output logic [2:0] rel);
    hit = -1;
    rel = '0;
    if (v) begin
      for (int i = 0; i < 3; i++) begin
        if (hit < 0 && m_en[i] && m_end[i] == pc) begin
          if (m_cnt[i] != 16'd0) hit = i;
          else rel[i] = 1'b1;
        end
      end
    end
  endfunction

  // R2/R9 register map
  function automatic logic [31:0] m_read(input logic [4:0] a);
    int s = int'(a[4:3]);
    logic [31:0] r = '0;
    if (s < 3) begin
      case (a[2:0])
        3'd0: r = m_start[s];
        3'd1: r = m_end[s];
        3'd2: r = {16'd0, m_cnt[s]};
        3'd3: r = {16'd0, m_init[s]};
        3'd4: r = {31'd0, m_en[s]};
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic void m_write(input logic [4:0] a, input logic [31:0] d);
    int s = int'(a[4:3]);
    if (s < 3) begin
      case (a[2:0])
        3'd0: m_start[s] = d;
        3'd1: m_end[s]   = d;
        3'd2: m_cnt[s]   = d[15:0];
        3'd3: m_init[s]  = d[15:0];
        3'd4: m_en[s]    = d[0];
        default: ;
      endcase
    end
  endfunction

  // one clock: drive, check combinational outputs, then advance model
  task automatic cyc(input logic v, input logic [31:0] pc, input logic we,
                     input logic [4:0] wa, input logic [31:0] wd,
                     input logic [4:0] ra, input string req);
    int hit;
    logic [2:0] rel;
    logic [2:0] ehit;
    @(negedge clk);
    fetch_valid = v; fetch_pc = pc; rf_we = we; rf_waddr = wa; rf_wdata = wd; rf_raddr = ra;
    #1;
    m_eval(v, pc, hit, rel);
    ehit  = (hit >= 0) ? 3'(1 << hit) : 3'b000;
    e_red = (hit >= 0);
    e_tgt = (hit >= 0) ? m_start[hit] : 32'd0;
    chk(redirect == e_red, {req, " R8 redirect"}, 32'(redirect), 32'(e_red));
    chk(loop_hit == ehit, {req, " R6 loop_hit"}, 32'(loop_hit), 32'(ehit));
    if (e_red) chk(redirect_target == e_tgt, {req, " R3 target"}, redirect_target, e_tgt);
    chk(rf_rdata == m_read(ra), {req, " R2 readback"}, rf_rdata, m_read(ra));
    if (hit >= 0) n_taken++;
    n_fall += $countones(rel);
    @(posedge clk);
    if (hit >= 0) m_cnt[hit] = m_cnt[hit] - 16'd1;
    for (int i = 0; i < 3; i++) if (rel[i]) m_cnt[i] = m_init[i];
    if (we) m_write(wa, wd);   // R7 write wins
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(1'b0, 32'hFFFF_FFF0, 1'b1, a, d, a, "setup");
  endtask

  task automatic rd_expect(input logic [4:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    fetch_valid = 1'b0; rf_we = 1'b0; rf_raddr = a;
    #1;
    chk(rf_rdata == exp, req, rf_rdata, exp);
  endtask

  // run fetch through the model-predicted path
  task automatic run_pc(input logic [31:0] pc0, input int n, input string req);
    logic [31:0] pc = pc0;
    for (int k = 0; k < n; k++) begin
      cyc(1'b1, pc, 1'b0, 5'd0, 32'd0, 5'd2, req);
      pc = e_red ? e_tgt : pc + 32'd4;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin : main
    logic [31:0] pc;
    m_reset();
    n_taken = 0; n_fall = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, and R5: disabled slots with end=0 at pc 0 do nothing
    for (int a = 0; a < 32; a++) rd_expect(5'(a), 32'd0, "R1 reset readback");
    cyc(1'b1, 32'd0, 1'b0, 5'd0, 32'd0, 5'd2, "R1 R5 no redirect after reset");

    // R3/R4: single loop, count 2 -> two back-branches, one fall-through
    wr(5'd0, 32'h100); wr(5'd1, 32'h10C); wr(5'd2, 32'd2); wr(5'd3, 32'd2); wr(5'd4, 32'd1);
    n_taken = 0; n_fall = 0;
    run_pc(32'h100, 14, "R3 simple loop");
    chk(n_taken == 2, "R3 back-branch count", 32'(n_taken), 32'd2);
    chk(n_fall == 1, "R4 fall-through count", 32'(n_fall), 32'd1);
    rd_expect(5'd2, 32'd2, "R4 count reloaded from initial");

    // R5: fetch not valid at the end address
    cyc(1'b0, 32'h10C, 1'b0, 5'd0, 32'd0, 5'd2, "R5 fetch idle");
    rd_expect(5'd2, 32'd2, "R5 count unchanged when idle");

    // R6: shared end address, slot1 is outer
    wr(5'd0, 32'h308); wr(5'd1, 32'h310); wr(5'd2, 32'd1); wr(5'd3, 32'd1);
    wr(5'd8, 32'h300); wr(5'd9, 32'h310); wr(5'd10, 32'd1); wr(5'd11, 32'd1); wr(5'd12, 32'd1);
    n_taken = 0; n_fall = 0;
    run_pc(32'h300, 40, "R6 nested shared end");
    chk(n_taken == 3, "R6 nested taken total", 32'(n_taken), 32'd3);
    chk(n_fall == 3, "R6 nested reloads", 32'(n_fall), 32'd3);
    rd_expect(5'd10, 32'd1, "R6 outer count reloaded");

    // R7: count written in the same cycle as a back-branch
    wr(5'd2, 32'd5);
    cyc(1'b1, 32'h310, 1'b1, 5'd2, 32'd9, 5'd2, "R7 write collides with branch");
    chk(e_red == 1'b1, "R7 branch uses old count", 32'(e_red), 32'd1);
    rd_expect(5'd2, 32'd9, "R7 written count survives");
    wr(5'd2, 32'd0);
    cyc(1'b1, 32'h310, 1'b1, 5'd2, 32'd4, 5'd2, "R7 write collides with reload");
    rd_expect(5'd2, 32'd4, "R7 write beats reload");

    // R5: disabling a slot removes its effect
    wr(5'd4, 32'd0);
    cyc(1'b1, 32'h310, 1'b0, 5'd0, 32'd0, 5'd2, "R5 disabled slot0");
    rd_expect(5'd2, 32'd4, "R5 disabled slot count kept");

    // R9: unmapped indices
    wr(5'd24, 32'hDEAD_BEEF); wr(5'd5, 32'h1234); wr(5'd15, 32'h55);
    rd_expect(5'd24, 32'd0, "R9 slot3 reads zero");
    rd_expect(5'd5, 32'd0, "R9 field5 reads zero");
    rd_expect(5'd8, 32'h300, "R9 neighbours untouched");

    // R2: field widths on readback
    wr(5'd19, 32'hABCD_1234);
    rd_expect(5'd19, 32'h0000_1234, "R2 initial count truncated");
    wr(5'd20, 32'hFFFF_FFFE);
    rd_expect(5'd20, 32'd0, "R2 control bit0 only");

    // random phase over a small window so matches and collisions are frequent
    void'($urandom(32'd1234));
    pc = 32'h0;
    for (int k = 0; k < 4000; k++) begin
      logic we = ($urandom % 100) < 25;
      logic [4:0] wa = 5'($urandom % 32);
      logic [31:0] wd;
      if (wa[2:0] <= 3'd1) wd = 32'(($urandom % 16) * 4);
      else if (wa[2:0] == 3'd4) wd = 32'($urandom % 4 != 0);
      else wd = 32'($urandom % 4);
      cyc(($urandom % 8) != 0, pc, we, wa, wd, 5'($urandom % 32), "R3 R4 R6 R7 random");
      if ($urandom % 16 == 0) pc = 32'(($urandom % 16) * 4);
      else pc = e_red ? e_tgt : ((pc + 32'd4) & 32'h3C);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule